// File: doc/BRIEF.md
# Line Peak Sampler with Watchdog

This block is the digital half of an input-voltage overpower compensation path in an offline converter controller. A coarse converter on the high-voltage input supplies a small code every cycle. The block keeps the largest code seen since the last sampling event. On each sampling event it copies that maximum into a held register and starts a fresh peak search. The held code then scales a compensation current that the current-sense network turns into an offset proportional to line voltage.

Sampling events come from two sources. With an AC-connected input, the sampling-level comparator flag drops each time the line falls through its sampling level, and that falling transition is the event. A DC input never crosses the level, so a millisecond watchdog fires the event after a fixed number of ticks with no crossing. Every crossing restarts the watchdog.

The compensation magnitude is the held code minus a fixed offset code, saturating at zero, so nothing is added at or below the line level that offset stands for. The magnitude is gated by an enable with hysteresis on feedback level. Two comparator flags set and clear this enable, and between them it keeps its last value.

Top module: `line_peak_sampler`

## Requirements
- R1: While `rst` is high and on the cycle after it, `held_code_o`, `comp_mag_o`, `comp_en_o` and `sample_evt_o` are all zero.
- R2: On a sampling event, `held_code_o` takes the largest `code_i` value sampled at any clock edge since the previous event, including the edge of the event itself.
- R3: A line event occurs at a clock edge where `above_lvl_i` was 1 at the previous edge and is 0 at this edge. A 0-to-1 transition causes no event. `sample_evt_o` is high for exactly the one cycle after each event edge.
- R4: With no line event, the event fires at the edge that carries the WD_TICKS-th asserted `tick_ms_i` since the last event or reset (32 by default).
- R5: Any event, from a line crossing or from the watchdog, restarts the watchdog count at zero.
- R6: `comp_en_o` is 1 after any edge at which `fb_hi_i` is 1.
- R7: `comp_en_o` is 0 after any edge at which `fb_lo_i` is 1 and `fb_hi_i` is 0.
- R8: `comp_en_o` keeps its value after an edge at which both `fb_hi_i` and `fb_lo_i` are 0.
- R9: `comp_mag_o` equals held code minus OFFSET_CODE (2 by default) when `comp_en_o` is 1 and the held code is above OFFSET_CODE. Otherwise it is 0.
- R10: After an event the peak restarts from zero, so codes seen before the event have no effect on the next held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | CODE_W | Coarse line-voltage code |
| above_lvl_i | input | 1 | Line is above the sampling level |
| fb_hi_i | input | 1 | Feedback above the upper threshold |
| fb_lo_i | input | 1 | Feedback below the lower threshold |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| held_code_o | output | CODE_W | Peak captured at the last event |
| comp_mag_o | output | CODE_W | Gated compensation magnitude |
| comp_en_o | output | 1 | Compensation enable |
| sample_evt_o | output | 1 | Pulse one cycle after each event |

## Verification
The assertions assume that the two feedback flags are never both high, since the upper threshold lies above the lower one. They also assume that the tick is a clean single-cycle pulse. The random stimulus therefore draws the feedback pair from three legal combinations only: high, low, or neither. It toggles the level flag rarely and pulses the tick about once in four cycles, so that both line events and watchdog events occur. Directed cases cover exact watchdog expiry, a restart after a crossing, both hysteresis thresholds and the offset edge.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_LINE = 2'd1,
    EVT_WD   = 2'd2
  } evt_src_e;
endpackage

// File: rtl/lps_evt_gen.sv
module lps_evt_gen
  import lps_pkg::*;
#(
  parameter int WD_TICKS = 32
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     above_i,
  input  logic     tick_i,
  output logic     evt_o,
  output evt_src_e src_o
);
  localparam int WDW = $clog2(WD_TICKS + 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WD_TICKS - 1);

  logic           above_q;
  logic [WDW-1:0] wd_q;
  logic           line_fall;
  logic           wd_fire;

  always_comb begin
    line_fall = above_q & ~above_i;
    wd_fire   = tick_i && (wd_q == WD_LAST);
    evt_o     = line_fall | wd_fire;
    if (line_fall)    src_o = EVT_LINE;
    else if (wd_fire) src_o = EVT_WD;
    else              src_o = EVT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      above_q <= 1'b0;
      wd_q    <= '0;
    end else begin
      above_q <= above_i;
      if (evt_o)       wd_q <= '0;
      else if (tick_i) wd_q <= wd_q + 1'b1;
    end
  end

  a_r4_wd_in_range: assert property (@(posedge clk) disable iff (rst)
    wd_q <= WD_LAST);
  a_r5_wd_restart: assert property (@(posedge clk) disable iff (rst)
    line_fall |=> (wd_q == '0));
  a_r3_no_rise_evt: assert property (@(posedge clk) disable iff (rst)
    (!above_q && above_i && !tick_i) |-> !evt_o);
endmodule

// File: rtl/lps_peak_hold.sv
module lps_peak_hold #(
  parameter int CODE_W      = 3,
  parameter int OFFSET_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              evt_i,
  output logic [CODE_W-1:0] held_o,
  output logic [CODE_W-1:0] mag_o
);
  localparam logic [CODE_W-1:0] OFF_C = CODE_W'(OFFSET_CODE);

  logic [CODE_W-1:0] peak_q;
  logic [CODE_W-1:0] held_q;
  logic [CODE_W-1:0] mag_q;
  logic [CODE_W-1:0] merged;
  logic [CODE_W-1:0] above_off;

  always_comb merged = (code_i > peak_q) ? code_i : peak_q;

  generate
    if (OFFSET_CODE == 0) begin : g_no_off
      always_comb above_off = merged;
    end else begin : g_off
      always_comb above_off = (merged > OFF_C) ? (merged - OFF_C) : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      peak_q <= '0;
      held_q <= '0;
      mag_q  <= '0;
    end else if (evt_i) begin
      held_q <= merged;
      mag_q  <= above_off;
      peak_q <= '0;
    end else begin
      peak_q <= merged;
    end
  end

  assign held_o = held_q;
  assign mag_o  = mag_q;

  a_r2_held_stable: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> $stable(held_q));
  a_r2_peak_covers: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> (peak_q >= $past(code_i)));
  a_r10_peak_cleared: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> (peak_q == '0));
  a_r9_mag_le_held: assert property (@(posedge clk) disable iff (rst)
    mag_q <= held_q);
endmodule

// File: rtl/lps_fb_hyst.sv
module lps_fb_hyst (
  input  logic clk,
  input  logic rst,
  input  logic hi_i,
  input  logic lo_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= 1'b0;
    else if (hi_i) en_q <= 1'b1;
    else if (lo_i) en_q <= 1'b0;
  end

  assign en_o = en_q;

  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    hi_i |=> en_q);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (lo_i && !hi_i) |=> !en_q);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!hi_i && !lo_i) |=> $stable(en_q));
endmodule

// File: rtl/line_peak_sampler.sv
module line_peak_sampler
  import lps_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int WD_TICKS    = 32,
  parameter int OFFSET_CODE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              above_lvl_i,
  input  logic              fb_hi_i,
  input  logic              fb_lo_i,
  input  logic              tick_ms_i,
  output logic [CODE_W-1:0] held_code_o,
  output logic [CODE_W-1:0] comp_mag_o,
  output logic              comp_en_o,
  output logic              sample_evt_o
);
  logic              evt;
  evt_src_e          src;
  logic              evt_q;
  logic [CODE_W-1:0] mag;
  logic              en;

  lps_evt_gen #(.WD_TICKS(WD_TICKS)) u_evt (
    .clk(clk), .rst(rst), .above_i(above_lvl_i), .tick_i(tick_ms_i),
    .evt_o(evt), .src_o(src)
  );

  lps_peak_hold #(.CODE_W(CODE_W), .OFFSET_CODE(OFFSET_CODE)) u_peak (
    .clk(clk), .rst(rst), .code_i(code_i), .evt_i(evt),
    .held_o(held_code_o), .mag_o(mag)
  );

  lps_fb_hyst u_hyst (
    .clk(clk), .rst(rst), .hi_i(fb_hi_i), .lo_i(fb_lo_i), .en_o(en)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= evt;
  end

  assign sample_evt_o = evt_q;
  assign comp_en_o    = en;
  assign comp_mag_o   = en ? mag : '0;

  a_r3_line_pulse: assert property (@(posedge clk) disable iff (rst)
    (src == EVT_LINE) |=> sample_evt_o);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (src == EVT_NONE) |=> !sample_evt_o);
  a_r9_mag_bound: assert property (@(posedge clk) disable iff (rst)
    comp_mag_o <= held_code_o);
endmodule

// File: tb/line_peak_sampler_tb_top.sv
module line_peak_sampler_tb_top;
  localparam int CW  = 3;
  localparam int WD  = 32;
  localparam int OFF = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] code_i = '0;
  logic          above_lvl_i = 1'b0, fb_hi_i = 1'b0, fb_lo_i = 1'b0, tick_ms_i = 1'b0;
  logic [CW-1:0] held_code_o, comp_mag_o;
  logic          comp_en_o, sample_evt_o;

  int total = 0, bad = 0;
  int m_peak, m_held, m_wd, m_en, m_evt, m_aq;

  always #2 clk = ~clk;

  line_peak_sampler #(.CODE_W(CW), .WD_TICKS(WD), .OFFSET_CODE(OFF)) dut_i (
    .clk(clk), .rst(rst), .code_i(code_i), .above_lvl_i(above_lvl_i),
    .fb_hi_i(fb_hi_i), .fb_lo_i(fb_lo_i), .tick_ms_i(tick_ms_i),
    .held_code_o(held_code_o), .comp_mag_o(comp_mag_o),
    .comp_en_o(comp_en_o), .sample_evt_o(sample_evt_o)
  );

  function automatic int exp_mag(int held, int en);
    if (en == 0 || held <= OFF) return 0;
    return held - OFF;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_peak = 0; m_held = 0; m_wd = 0; m_en = 0; m_evt = 0; m_aq = 0;
  endtask

  task automatic check_all();
    chk("R2 held", held_code_o, m_held);
    chk("R3 event", sample_evt_o, m_evt);
    chk("R6 enable", comp_en_o, m_en);
    chk("R9 magnitude", comp_mag_o, exp_mag(m_held, m_en));
  endtask

  task automatic step(input int a, input int c, input int hi, input int lo, input int t);
    int fall, wdf, mx;
    @(negedge clk);
    above_lvl_i = a[0]; code_i = CW'(c); fb_hi_i = hi[0]; fb_lo_i = lo[0]; tick_ms_i = t[0];
    @(posedge clk);
    fall = (m_aq == 1 && a == 0) ? 1 : 0;
    wdf  = (t != 0 && m_wd == WD - 1) ? 1 : 0;
    mx   = (c > m_peak) ? c : m_peak;
    if (fall != 0 || wdf != 0) begin
      m_held = mx; m_peak = 0; m_wd = 0; m_evt = 1;
    end else begin
      m_peak = mx; m_evt = 0;
      if (t != 0) m_wd++;
    end
    m_aq = a;
    if (hi != 0)      m_en = 1;
    else if (lo != 0) m_en = 0;
    #1;
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed, a, hi, lo, r;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 held in reset", held_code_o, 0);
    chk("R1 mag in reset", comp_mag_o, 0);
    chk("R1 en in reset", comp_en_o, 0);
    chk("R1 evt in reset", sample_evt_o, 0);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 0, 0);
    chk("R1 after reset", held_code_o + comp_en_o + sample_evt_o, 0);

    // R2/R3: rising edge no event; codes ramp, falling edge captures max
    step(1, 3, 1, 0, 0);
    chk("R3 rise no event", sample_evt_o, 0);
    step(1, 6, 0, 0, 0);
    step(1, 4, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R3 fall event", sample_evt_o, 1);
    chk("R2 max captured", held_code_o, 6);
    chk("R9 mag above offset", comp_mag_o, 4);
    step(0, 1, 0, 0, 0);
    chk("R3 single pulse", sample_evt_o, 0);

    // R10: low codes after event replace earlier peak
    step(1, 2, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R10 peak restarted", held_code_o, 2);
    chk("R9 mag at offset is zero", comp_mag_o, 0);

    // R8/R7: hysteresis
    step(0, 0, 0, 0, 0);
    chk("R8 hold high", comp_en_o, 1);
    step(0, 0, 0, 1, 0);
    chk("R7 clear", comp_en_o, 0);
    step(0, 0, 0, 0, 0);
    chk("R8 hold low", comp_en_o, 0);

    // R4: watchdog after WD ticks
    for (int i = 0; i < WD - 1; i++) step(0, 7, 1, 0, 1);
    chk("R4 no early fire", sample_evt_o, 0);
    step(0, 5, 1, 0, 1);
    chk("R4 watchdog fire", sample_evt_o, 1);
    chk("R4 held from dc", held_code_o, 7);

    // R5: crossing mid-count restarts the watchdog
    for (int i = 0; i < 20; i++) step(0, 3, 0, 0, 1);
    step(1, 3, 0, 0, 1);
    step(0, 3, 0, 0, 0);
    chk("R5 crossing event", sample_evt_o, 1);
    for (int i = 0; i < WD - 1; i++) step(0, 3, 0, 0, 1);
    chk("R5 count restarted", sample_evt_o, 0);
    step(0, 3, 0, 0, 1);
    chk("R5 fire after full count", sample_evt_o, 1);

    // random mix
    a = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99) == 0) a = 1 - a;
      r = $urandom_range(9);
      hi = (r == 0) ? 1 : 0;
      lo = (r == 1) ? 1 : 0;
      step(a, $urandom_range(7), hi, lo, ($urandom_range(3) == 0) ? 1 : 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule